// File: doc/BRIEF.md
# Serial Overhead Byte Insertion Port

This block gathers two low-rate serial overhead channels and supplies their byte values to the transmit overhead multiplexer. The first is a one-byte user channel. The second is a three-byte section data communication channel. For each channel the block generates a bit clock, and for the user channel also a byte sync pulse. It shifts the external serial data in on those clocks and copies each complete set of bytes into holding registers at the frame boundary. The multiplexer reads these registers when it reaches the matching frame slots.

All bit timing is derived from a frame-start strobe supplied by the chip's frame timing. A frame lasts `FRAME_CYCLES` system clocks. The user channel gets 8 bit periods per frame and the data channel gets 24, so each frame carries an exact number of bits. A bit is captured in the middle of its period.

When the add/drop mode input is set, the serial path is bypassed and the bytes received on the incoming line are passed straight through to the outputs. If a frame ends before its bits are complete, the holding registers keep their old contents and a sticky per-channel error flag is raised.

Top module: `ohSerialInsert`

## Requirements
- R1: After reset, all transmit byte outputs read 0 (with add/drop mode off), both error flags read 0 and both serial clock outputs are low.
- R2: Counting position p from 0 in the cycle after a frameStart cycle, userClkOut is high exactly when (p mod FRAME_CYCLES/8) is at least half the period, and is low otherwise.
- R3: userSyncOut is high during the first user-channel bit period of each frame (p < FRAME_CYCLES/8) and is low for the rest of the frame.
- R4: dccClkOut follows the same rule as R2 with a period of FRAME_CYCLES/24.
- R5: Each user-channel bit is captured in the cycle where its clock period reaches half, most significant bit first. The 8 bits of a frame appear on txUserByte in the cycle after that frame's frameStart cycle.
- R6: The 24 data-channel bits of a frame are taken MSB first and split in arrival order: bits 1-8 go to txDcc1, bits 9-16 to txDcc2 and bits 17-24 to txDcc3. They appear together in the cycle after frameStart.
- R7: Between frame boundaries the transmit byte outputs stay constant, whatever serial activity takes place.
- R8: If frameStart arrives before all bits of a channel have been captured, that channel's outputs keep their previous value and its error flag goes to 1. The flag stays at 1 until reset.
- R9: The first frame boundary after reset raises no error, even when that frame was short.
- R10: While addDropEn is 1, the transmit byte outputs follow rxUserByte and rxDcc1..3 combinationally and no short-frame error is raised. When addDropEn returns to 0, the outputs show the holding registers again.
- R11: In a frame longer than nominal, bits beyond the 8th (user) or 24th (data channel) are ignored, and the captured bytes are the first bits of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle strobe; the next cycle is position 0 of a frame |
| addDropEn | input | 1 | 1 = pass received line bytes through instead of serial data |
| userSerIn | input | 1 | User-channel serial data |
| dccSerIn | input | 1 | Data-channel serial data |
| rxUserByte | input | 8 | User byte received on the incoming line |
| rxDcc1 | input | 8 | First received data-channel byte |
| rxDcc2 | input | 8 | Second received data-channel byte |
| rxDcc3 | input | 8 | Third received data-channel byte |
| userClkOut | output | 1 | User-channel bit clock (8 periods per frame) |
| userSyncOut | output | 1 | High during the first user bit period of the frame |
| dccClkOut | output | 1 | Data-channel bit clock (24 periods per frame) |
| txUserByte | output | 8 | User byte for insertion |
| txDcc1 | output | 8 | First data-channel byte for insertion |
| txDcc2 | output | 8 | Second data-channel byte for insertion |
| txDcc3 | output | 8 | Third data-channel byte for insertion |
| userShortErr | output | 1 | Sticky flag: a user-channel frame ended before 8 bits were captured |
| dccShortErr | output | 1 | Sticky flag: a data-channel frame ended before 24 bits were captured |

## Verification
Nominal frames carry asymmetric bit patterns such as 0xA5 against 0x5A, and 0x01/0x80/0xFF split across the three data bytes. These patterns show whether bit order is reversed or the data bytes are swapped. A long frame with ones driven after the last valid bit shows whether capture stops at the bit count or keeps shifting. A short frame followed by a nominal one separates holding the old value from partial loading, and shows whether the error flag is sticky. A repeat after reset with add/drop mode on checks pass-through, suppression of the error, and the return to the holding registers. Clock and sync levels are compared against position-derived expectations in every cycle of each timed frame.

// File: rtl/ohSerialPkg.sv
package ohSerialPkg;
  // Strobes passed from the timing control to the datapath
  typedef struct packed {
    logic boundary;    // frame ends with this cycle
    logic sampleUser;  // capture user-channel bit this cycle
    logic sampleDcc;   // capture data-channel bit this cycle
  } ohStrobe_t;
endpackage

// File: rtl/ohBitTimer.sv
module ohBitTimer #(
  parameter int PERIOD = 2430,
  parameter int BITS   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameStart,
  output logic sampleNow,
  output logic clkLevel,
  output logic firstBit
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CW = $clog2(BITS + 1);
  localparam logic [PW-1:0] LAST_PH = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HALF_PH = PW'(PERIOD / 2);
  localparam logic [CW-1:0] MAX_CNT = CW'(BITS);

  logic [PW-1:0] phaseQ;
  logic [CW-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= '0;
      periodCnt <= '0;
    end else if (frameStart) begin
      phaseQ    <= '0;
      periodCnt <= '0;
    end else if (phaseQ == LAST_PH) begin
      phaseQ <= '0;
      if (periodCnt != MAX_CNT) periodCnt <= periodCnt + CW'(1);
    end else begin
      phaseQ <= phaseQ + PW'(1);
    end
  end

  assign clkLevel  = (phaseQ >= HALF_PH);
  assign sampleNow = (phaseQ == HALF_PH) && !frameStart;
  assign firstBit  = (periodCnt == '0);

  // R2/R4: capture only while the generated clock is high
  assert_sample_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleNow |-> clkLevel);
  // R2/R4: every rising clock edge inside a frame gives a capture
  assert_rise_samples_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(clkLevel) && !frameStart) |-> sampleNow);
endmodule

// File: rtl/ohSerialCtrl.sv
module ohSerialCtrl
  import ohSerialPkg::*;
#(
  parameter int FRAME_CYCLES = 19440,
  parameter int USER_BITS    = 8,
  parameter int DCC_BITS     = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  output ohStrobe_t strobes,
  output logic      userClkOut,
  output logic      userSyncOut,
  output logic      dccClkOut
);
  localparam int USER_PERIOD = FRAME_CYCLES / USER_BITS;
  localparam int DCC_PERIOD  = FRAME_CYCLES / DCC_BITS;

  logic userSample, dccSample, dccFirst;

  ohBitTimer #(.PERIOD(USER_PERIOD), .BITS(USER_BITS)) userTimer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .sampleNow(userSample), .clkLevel(userClkOut), .firstBit(userSyncOut)
  );

  ohBitTimer #(.PERIOD(DCC_PERIOD), .BITS(DCC_BITS)) dccTimer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .sampleNow(dccSample), .clkLevel(dccClkOut), .firstBit(dccFirst)
  );

  always_comb begin
    strobes.boundary   = frameStart;
    strobes.sampleUser = userSample;
    strobes.sampleDcc  = dccSample;
  end

  // R3/R4: both ports start their first bit period together after a boundary
  assert_first_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (userSyncOut && dccFirst));
endmodule

// File: rtl/ohShiftChannel.sv
module ohShiftChannel #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            boundary,
  input  logic            sample,
  input  logic            serIn,
  input  logic            addDrop,
  output logic [BITS-1:0] holdQ,
  output logic            errQ
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BITS);

  logic [BITS-1:0] shiftQ;
  logic [CW-1:0]   bitsIn;
  logic            framedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitsIn  <= '0;
      holdQ   <= '0;
      errQ    <= 1'b0;
      framedQ <= 1'b0;
    end else if (boundary) begin
      bitsIn  <= '0;
      framedQ <= 1'b1;
      if (bitsIn == FULL) holdQ <= shiftQ;
      else if (framedQ && !addDrop) errQ <= 1'b1;
    end else if (sample && (bitsIn != FULL)) begin
      shiftQ <= {shiftQ[BITS-2:0], serIn};
      bitsIn <= bitsIn + CW'(1);
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(holdQ));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
  assert_no_overshift_R11: assert property (@(posedge clk) disable iff (!rstN)
    bitsIn <= FULL);
  assert_unframed_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !framedQ |=> !errQ);
  assert_adddrop_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (addDrop && !errQ) |=> !errQ);
endmodule

// File: rtl/ohSerialData.sv
module ohSerialData
  import ohSerialPkg::*;
#(
  parameter int USER_BITS = 8,
  parameter int DCC_BYTES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ohStrobe_t                strobes,
  input  logic                     addDropEn,
  input  logic                     userSerIn,
  input  logic                     dccSerIn,
  input  logic [USER_BITS-1:0]     rxUser,
  input  logic [DCC_BYTES*8-1:0]   rxDcc,
  output logic [USER_BITS-1:0]     txUser,
  output logic [DCC_BYTES*8-1:0]   txDcc,
  output logic                     userErr,
  output logic                     dccErr
);
  localparam int DCC_BITS = DCC_BYTES * 8;

  logic [USER_BITS-1:0] userHold;
  logic [DCC_BITS-1:0]  dccHold;

  ohShiftChannel #(.BITS(USER_BITS)) userChan (
    .clk(clk), .rstN(rstN), .boundary(strobes.boundary),
    .sample(strobes.sampleUser), .serIn(userSerIn), .addDrop(addDropEn),
    .holdQ(userHold), .errQ(userErr)
  );

  ohShiftChannel #(.BITS(DCC_BITS)) dccChan (
    .clk(clk), .rstN(rstN), .boundary(strobes.boundary),
    .sample(strobes.sampleDcc), .serIn(dccSerIn), .addDrop(addDropEn),
    .holdQ(dccHold), .errQ(dccErr)
  );

  assign txUser = addDropEn ? rxUser : userHold;

  // per-byte source selection; first-arriving bits land in the top byte
  for (genvar b = 0; b < DCC_BYTES; b++) begin : gDccSel
    assign txDcc[b*8 +: 8] = addDropEn ? rxDcc[b*8 +: 8] : dccHold[b*8 +: 8];
  end
endmodule

// File: rtl/ohSerialInsert.sv
module ohSerialInsert
  import ohSerialPkg::*;
#(
  parameter int FRAME_CYCLES = 19440
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       addDropEn,
  input  logic       userSerIn,
  input  logic       dccSerIn,
  input  logic [7:0] rxUserByte,
  input  logic [7:0] rxDcc1,
  input  logic [7:0] rxDcc2,
  input  logic [7:0] rxDcc3,
  output logic       userClkOut,
  output logic       userSyncOut,
  output logic       dccClkOut,
  output logic [7:0] txUserByte,
  output logic [7:0] txDcc1,
  output logic [7:0] txDcc2,
  output logic [7:0] txDcc3,
  output logic       userShortErr,
  output logic       dccShortErr
);
  localparam int USER_BITS = 8;
  localparam int DCC_BYTES = 3;
  localparam int DCC_BITS  = DCC_BYTES * 8;

  ohStrobe_t strobes;
  logic [DCC_BITS-1:0] txDccBus;

  ohSerialCtrl #(
    .FRAME_CYCLES(FRAME_CYCLES), .USER_BITS(USER_BITS), .DCC_BITS(DCC_BITS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .strobes(strobes),
    .userClkOut(userClkOut), .userSyncOut(userSyncOut), .dccClkOut(dccClkOut)
  );

  ohSerialData #(.USER_BITS(USER_BITS), .DCC_BYTES(DCC_BYTES)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addDropEn(addDropEn),
    .userSerIn(userSerIn), .dccSerIn(dccSerIn),
    .rxUser(rxUserByte), .rxDcc({rxDcc1, rxDcc2, rxDcc3}),
    .txUser(txUserByte), .txDcc(txDccBus),
    .userErr(userShortErr), .dccErr(dccShortErr)
  );

  assign {txDcc1, txDcc2, txDcc3} = txDccBus;
endmodule

// File: tb/ohSerialInsert_test.sv
`timescale 1ns/1ps
module ohSerialInsert_test;
  localparam int FC = 240;
  localparam int PU = FC / 8;
  localparam int PD = FC / 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, addDropEn = 1'b0, userSerIn = 1'b0, dccSerIn = 1'b0;
  logic [7:0] rxUserByte = 8'h00, rxDcc1 = 8'h00, rxDcc2 = 8'h00, rxDcc3 = 8'h00;
  logic userClkOut, userSyncOut, dccClkOut, userShortErr, dccShortErr;
  logic [7:0] txUserByte, txDcc1, txDcc2, txDcc3;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ohSerialInsert #(.FRAME_CYCLES(FC)) uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .addDropEn(addDropEn),
    .userSerIn(userSerIn), .dccSerIn(dccSerIn), .rxUserByte(rxUserByte),
    .rxDcc1(rxDcc1), .rxDcc2(rxDcc2), .rxDcc3(rxDcc3),
    .userClkOut(userClkOut), .userSyncOut(userSyncOut), .dccClkOut(dccClkOut),
    .txUserByte(txUserByte), .txDcc1(txDcc1), .txDcc2(txDcc2), .txDcc3(txDcc3),
    .userShortErr(userShortErr), .dccShortErr(dccShortErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] dccNow();
    return {txDcc1, txDcc2, txDcc3};
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    frameStart = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Called at a negedge that is position 0; returns at position 0 of the next frame
  task automatic runFrame(input int len, input logic [7:0] ub, input logic [23:0] db,
                          input bit chk);
    int bad2, bad3, bad4, bad7;
    logic [7:0] startU;
    logic [23:0] startD;
    bad2 = 0; bad3 = 0; bad4 = 0; bad7 = 0;
    startU = txUserByte;
    startD = dccNow();
    for (int p = 0; p < len; p++) begin
      frameStart = (p == len - 1);
      userSerIn = (p / PU < 8) ? ub[7 - p / PU] : 1'b1;
      dccSerIn  = (p / PD < 24) ? db[23 - p / PD] : 1'b1;
      if (userClkOut !== ((p % PU) >= PU / 2)) bad2++;
      if (userSyncOut !== (p < PU)) bad3++;
      if (dccClkOut !== ((p % PD) >= PD / 2)) bad4++;
      if (txUserByte !== startU || dccNow() !== startD) bad7++;
      @(negedge clk);
    end
    if (chk) begin
      check(bad2 == 0, "R2 user clock mismatches", bad2, 0);
      check(bad3 == 0, "R3 sync mismatches", bad3, 0);
      check(bad4 == 0, "R4 dcc clock mismatches", bad4, 0);
      check(bad7 == 0, "R7 output changed mid-frame", bad7, 0);
    end
  endtask

  task automatic testReset();
    rxUserByte = 8'h77; rxDcc1 = 8'h11; rxDcc2 = 8'h22; rxDcc3 = 8'h33;
    addDropEn = 1'b0;
    doReset();
    check(txUserByte === 8'h00, "R1 txUserByte", txUserByte, 0);
    check(dccNow() === 24'h0, "R1 txDcc", dccNow(), 0);
    check({userShortErr, dccShortErr} === 2'b00, "R1 errors", {userShortErr, dccShortErr}, 0);
    check({userClkOut, dccClkOut} === 2'b00, "R1 clocks", {userClkOut, dccClkOut}, 0);
    runFrame(4, 8'h00, 24'h0, 0);
    check({userShortErr, dccShortErr} === 2'b00, "R9 first short boundary",
          {userShortErr, dccShortErr}, 0);
    check(txUserByte === 8'h00, "R9 hold unchanged", txUserByte, 0);
  endtask

  task automatic testNominal(input logic [7:0] ub, input logic [23:0] db);
    runFrame(FC, ub, db, 1);
    check(txUserByte === ub, "R5 user byte", txUserByte, ub);
    check(txDcc1 === db[23:16], "R6 txDcc1", txDcc1, db[23:16]);
    check(txDcc2 === db[15:8],  "R6 txDcc2", txDcc2, db[15:8]);
    check(txDcc3 === db[7:0],   "R6 txDcc3", txDcc3, db[7:0]);
    check({userShortErr, dccShortErr} === 2'b00, "R8 no error on full frame",
          {userShortErr, dccShortErr}, 0);
  endtask

  task automatic testLongFrame();
    runFrame(FC + 60, 8'hC3, 24'h123456, 1);
    check(txUserByte === 8'hC3, "R11 long frame user", txUserByte, 8'hC3);
    check(dccNow() === 24'h123456, "R11 long frame dcc", dccNow(), 24'h123456);
    check({userShortErr, dccShortErr} === 2'b00, "R11 no error",
          {userShortErr, dccShortErr}, 0);
  endtask

  task automatic testShortFrame();
    runFrame(150, 8'h0F, 24'hABCDEF, 1);
    check(txUserByte === 8'hC3, "R8 user hold kept", txUserByte, 8'hC3);
    check(dccNow() === 24'h123456, "R8 dcc hold kept", dccNow(), 24'h123456);
    check(userShortErr === 1'b1, "R8 user error", userShortErr, 1);
    check(dccShortErr === 1'b1, "R8 dcc error", dccShortErr, 1);
    runFrame(FC, 8'h96, 24'h654321, 1);
    check(txUserByte === 8'h96, "R5 recovery byte", txUserByte, 8'h96);
    check(dccNow() === 24'h654321, "R6 recovery bytes", dccNow(), 24'h654321);
    check({userShortErr, dccShortErr} === 2'b11, "R8 errors sticky",
          {userShortErr, dccShortErr}, 2'b11);
  endtask

  task automatic testAddDrop();
    testReset();
    addDropEn = 1'b1;
    rxUserByte = 8'hE1; rxDcc1 = 8'hD2; rxDcc2 = 8'hC3; rxDcc3 = 8'hB4;
    #1;
    check(txUserByte === 8'hE1, "R10 user pass-through", txUserByte, 8'hE1);
    check(dccNow() === 24'hD2C3B4, "R10 dcc pass-through", dccNow(), 24'hD2C3B4);
    @(negedge clk);
    runFrame(150, 8'hFF, 24'hFFFFFF, 0);
    check({userShortErr, dccShortErr} === 2'b00, "R10 error suppressed",
          {userShortErr, dccShortErr}, 0);
    rxUserByte = 8'h3A; rxDcc2 = 8'h5C;
    #1;
    check(txUserByte === 8'h3A, "R10 follows rx change", txUserByte, 8'h3A);
    check(dccNow() === 24'hD25CB4, "R10 dcc follows rx", dccNow(), 24'hD25CB4);
    addDropEn = 1'b0;
    #1;
    check(txUserByte === 8'h00, "R10 back to hold", txUserByte, 8'h00);
    check(dccNow() === 24'h0, "R10 dcc back to hold", dccNow(), 24'h0);
  endtask

  initial begin
    testReset();
    testNominal(8'hA5, 24'h3C817E);
    testNominal(8'h5A, 24'h0180FF);
    testLongFrame();
    testShortFrame();
    testAddDrop();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule